// File: doc/BRIEF.md
# Per-Frame GPIO Matrix Engine

This block drives sixteen general-purpose pins spread over two GPIO banks from one 32-bit command word per frame. The word sits in memory. Each bit of its low half sets the direction of a channel, and each bit of its high half carries that channel's level. When a request is accepted, the engine does the following in order:
- fetches the word;
- merges the new direction bits into each bank's active-low output-enable register;
- samples both banks' input registers;
- writes a clear mask and a set mask to each bank as one paired write;
- stores the word back with the sampled input levels in place.

A frame loop pulses `start` once per converter transfer and presents the low bits of its transfer counter on `xfer_phase`. The engine only acts when `enable` is high and that phase is zero, so the pins are serviced on every fourth transfer. The word pointer is loaded while the engine is idle. It advances one word after each processed frame, so consecutive frames walk a word buffer.

Top module: `gpio_matrix_engine`

## Requirements
- R1: For a channel whose direction bit (word bit ch) is 0, the engine writes 0 to that pin's output-enable bit. It sets the pin's bit in the set mask when word bit ch+16 is 1, or in the clear mask when it is 0, and never in both.
- R2: For a channel whose direction bit is 1, the engine writes 1 to that pin's output-enable bit and leaves the pin's set-mask and clear-mask bits at 0.
- R3: Output-enable bits of pins outside the matrix are written back with the value read in the same frame. Set-mask and clear-mask bits of such pins are 0, because both masks start from zero every frame.
- R4: Channel-to-pin map:
  - channels 0..3 drive bank B bits 2, 3, 5, 4;
  - channels 4..10 drive bank A bits 13, 12, 28, 18, 15, 14, 19;
  - channels 11..15 drive bank B bits 1, 22, 24, 23, 25.
- R5: The stored word equals the fetched word, except that for each input channel bit ch+16 takes the sampled level of that channel's pin.
- R6: One frame issues exactly ten transfers, in this order:
  1. memory read;
  2. OE read A, then OE write A;
  3. OE read B, then OE write B;
  4. input read A, then input read B;
  5. pair write A, then pair write B;
  6. memory write.
  `bus_bank` is 0 for bank A and 1 for bank B. `bus_reg` is 0 for OE, 1 for input and 2 for the pair. A pair write carries the clear mask in `bus_wdata[31:0]` and the set mask in `bus_wdata[63:32]`.
- R7: A `start` pulse is ignored, with no transfer, no `done` and no pointer change, unless `enable` is 1 and `xfer_phase` is 0.
- R8: The write-back uses the same address as the fetch. After each processed word the pointer advances by 4 bytes.
- R9: `done` is high for exactly one cycle, in the cycle after the write-back is acknowledged.
- R10: A `start` that arrives while a frame is in progress is ignored and does not cause a second frame.
- R11: After reset the engine is idle, with no strobe active and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Matrix servicing enabled |
| start | input | 1 | Per-transfer request pulse |
| xfer_phase | input | SKIP_BITS | Low bits of the transfer counter |
| ptr_load | input | 1 | Load word pointer (idle only) |
| ptr_init | input | ADDR_W | Pointer value to load |
| mem_rd | output | 1 | Memory read strobe, held until acknowledged |
| mem_wr | output | 1 | Memory write strobe, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the command word |
| mem_wdata | output | 32 | Updated command word |
| mem_rdata | input | 32 | Fetched command word |
| mem_ack | input | 1 | Memory transfer complete |
| bus_rd | output | 1 | Bank register read strobe |
| bus_wr | output | 1 | Bank register write strobe |
| bus_bank | output | 1 | Bank select, 0 = A, 1 = B |
| bus_reg | output | 2 | Register select: 0 OE, 1 input, 2 clear/set pair |
| bus_wdata | output | 64 | OE value in [31:0], or clear mask [31:0] and set mask [63:32] |
| bus_rdata | input | 32 | Register read data |
| bus_ack | input | 1 | Register transfer complete |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench builds the engine with its defaults: a 16-bit byte address, a 4-byte pointer step and a two-bit phase field. With these values the gating on every fourth transfer, the pointer walk across consecutive words and both banks' full 32-bit registers can all be reached. The bench's bus models answer one cycle after each strobe and log every transfer, so the ten-step order and each written value can be compared with masks the bench derives from its own copy of the channel map. Patterns include all outputs, all inputs and a mixed split with non-matrix OE bits preset, so the preservation of unrelated pins shows up at the bus.

// File: rtl/gpio_matrix_pkg.sv
// Shared types and channel map for the GPIO matrix engine.
// Assumes 16 channels, two 32-bit banks, and a fixed channel-to-pin map.
package gpio_matrix_pkg;

    localparam int NUM_CH = 16;
    localparam int WORD_W = 32;
    localparam int BANK_W = 32;

    typedef enum logic [1:0] {
        REG_OE   = 2'd0,
        REG_DIN  = 2'd1,
        REG_PAIR = 2'd2
    } reg_sel_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD,
        S_OE_RD_A, S_OE_WR_A, S_OE_RD_B, S_OE_WR_B,
        S_IN_A, S_IN_B, S_PAIR_A, S_PAIR_B,
        S_STORE, S_DONE
    } eng_state_e;

    // Which bank a channel lives on (1 = bank B).
    function automatic logic chan_on_b(input int ch);
        return !(ch >= 4 && ch <= 10);
    endfunction

    // Bit position of a channel inside its bank.
    function automatic logic [4:0] chan_bit(input int ch);
        case (ch)
            0:  return 5'd2;
            1:  return 5'd3;
            2:  return 5'd5;
            3:  return 5'd4;
            4:  return 5'd13;
            5:  return 5'd12;
            6:  return 5'd28;
            7:  return 5'd18;
            8:  return 5'd15;
            9:  return 5'd14;
            10: return 5'd19;
            11: return 5'd1;
            12: return 5'd22;
            13: return 5'd24;
            14: return 5'd23;
            default: return 5'd25;
        endcase
    endfunction

    // Pins of one bank that belong to the matrix.
    function automatic logic [BANK_W-1:0] bank_pins(input logic on_b);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NUM_CH; ch++)
            if (chan_on_b(ch) == on_b) m[chan_bit(ch)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gpio_matrix_bank.sv
// Per-bank mask builder. From the command word and the bank's current
// output-enable value it forms the new OE value and the set and clear masks.
// Assumes OE is active low (0 = output). Purely combinational; clk/rst_n
// serve the local checks only.
module gpio_matrix_bank
    import gpio_matrix_pkg::*;
#(
    parameter bit ON_B = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic [BANK_W-1:0] oe_cur,
    output logic [BANK_W-1:0] oe_new,
    output logic [BANK_W-1:0] set_mask,
    output logic [BANK_W-1:0] clr_mask
);
    localparam int HALF = WORD_W / 2;

    // Merge direction bits into OE and pick set or clear per output pin.
    always_comb begin
        oe_new   = oe_cur;
        set_mask = '0;
        clr_mask = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (chan_on_b(ch) == ON_B) begin
                if (word[ch]) begin
                    oe_new[chan_bit(ch)] = 1'b1;
                end else begin
                    oe_new[chan_bit(ch)] = 1'b0;
                    if (word[ch+HALF]) set_mask[chan_bit(ch)] = 1'b1;
                    else               clr_mask[chan_bit(ch)] = 1'b1;
                end
            end
        end
    end

    // R1: a pin is never both set and cleared
    p_masks_disjoint_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask & clr_mask) == '0);

    // R2: masks only touch pins that are outputs
    p_input_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask | clr_mask) & oe_new) == '0);

endmodule

// File: rtl/gpio_matrix_sample.sv
// Input write-back. Copies each input channel's sampled pin level into
// bit ch+16 of the command word; output channels are left as fetched.
// Assumes both banks' input registers were captured in the same frame.
module gpio_matrix_sample
    import gpio_matrix_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [BANK_W-1:0] din_a,
    input  logic [BANK_W-1:0] din_b,
    output logic [WORD_W-1:0] word_upd
);
    localparam int HALF = WORD_W / 2;

    // Replace level bits of input channels with their sampled pins.
    always_comb begin
        word_upd = word;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (word[ch])
                word_upd[ch+HALF] = chan_on_b(ch) ? din_b[chan_bit(ch)]
                                                  : din_a[chan_bit(ch)];
        end
    end

endmodule

// File: rtl/gpio_matrix_seq.sv
// Frame sequencer. Accepts a gated request, then steps through the fixed
// transfer order (fetch, OE A, OE B, inputs, pair writes, store), holding
// each strobe until acknowledged. Owns the word pointer.
// Assumes ack arrives on a later cycle than the strobe rises.
module gpio_matrix_seq
    import gpio_matrix_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SKIP_BITS = 2,
    parameter int PTR_STEP  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 start,
    input  logic [SKIP_BITS-1:0] xfer_phase,
    input  logic                 ptr_load,
    input  logic [ADDR_W-1:0]    ptr_init,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic [WORD_W-1:0]    mem_rdata,
    input  logic                 mem_ack,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic                 bus_bank,
    output logic [1:0]           bus_reg,
    output logic [2*BANK_W-1:0]  bus_wdata,
    input  logic [BANK_W-1:0]    bus_rdata,
    input  logic                 bus_ack,
    output logic [WORD_W-1:0]    word_q,
    output logic [BANK_W-1:0]    oe_q,
    output logic [BANK_W-1:0]    din_a_q,
    output logic [BANK_W-1:0]    din_b_q,
    input  logic [BANK_W-1:0]    oe_new_a,
    input  logic [BANK_W-1:0]    oe_new_b,
    input  logic [BANK_W-1:0]    set_a,
    input  logic [BANK_W-1:0]    clr_a,
    input  logic [BANK_W-1:0]    set_b,
    input  logic [BANK_W-1:0]    clr_b,
    input  logic [WORD_W-1:0]    word_upd,
    output logic                 done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PTR_STEP);

    eng_state_e          state;
    logic [ADDR_W-1:0]   ptr_q;
    logic                go_ok;
    logic                acked;

    assign go_ok = enable && (xfer_phase == '0);
    assign acked = mem_ack || bus_ack;

    // State register: advance on each acknowledged transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            case (state)
                S_IDLE:    if (start && go_ok) state <= S_LOAD;
                S_LOAD:    if (acked) state <= S_OE_RD_A;
                S_OE_RD_A: if (acked) state <= S_OE_WR_A;
                S_OE_WR_A: if (acked) state <= S_OE_RD_B;
                S_OE_RD_B: if (acked) state <= S_OE_WR_B;
                S_OE_WR_B: if (acked) state <= S_IN_A;
                S_IN_A:    if (acked) state <= S_IN_B;
                S_IN_B:    if (acked) state <= S_PAIR_A;
                S_PAIR_A:  if (acked) state <= S_PAIR_B;
                S_PAIR_B:  if (acked) state <= S_STORE;
                S_STORE:   if (acked) state <= S_DONE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Capture registers for fetched word, current OE and input samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            oe_q    <= '0;
            din_a_q <= '0;
            din_b_q <= '0;
        end else begin
            if (state == S_LOAD && mem_ack) word_q <= mem_rdata;
            if ((state == S_OE_RD_A || state == S_OE_RD_B) && bus_ack) oe_q <= bus_rdata;
            if (state == S_IN_A && bus_ack) din_a_q <= bus_rdata;
            if (state == S_IN_B && bus_ack) din_b_q <= bus_rdata;
        end
    end

    // Word pointer: load while idle, step after each stored word.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ptr_q <= '0;
        else if (state == S_IDLE && ptr_load) ptr_q <= ptr_init;
        else if (state == S_STORE && mem_ack) ptr_q <= ptr_q + STEP;
    end

    // Strobe and data decode per state.
    always_comb begin
        mem_rd    = (state == S_LOAD);
        mem_wr    = (state == S_STORE);
        mem_addr  = ptr_q;
        mem_wdata = word_upd;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_bank  = 1'b0;
        bus_reg   = REG_OE;
        bus_wdata = '0;
        case (state)
            S_OE_RD_A: bus_rd = 1'b1;
            S_OE_WR_A: begin bus_wr = 1'b1; bus_wdata = {{BANK_W{1'b0}}, oe_new_a}; end
            S_OE_RD_B: begin bus_rd = 1'b1; bus_bank = 1'b1; end
            S_OE_WR_B: begin bus_wr = 1'b1; bus_bank = 1'b1;
                             bus_wdata = {{BANK_W{1'b0}}, oe_new_b}; end
            S_IN_A:    begin bus_rd = 1'b1; bus_reg = REG_DIN; end
            S_IN_B:    begin bus_rd = 1'b1; bus_bank = 1'b1; bus_reg = REG_DIN; end
            S_PAIR_A:  begin bus_wr = 1'b1; bus_reg = REG_PAIR; bus_wdata = {set_a, clr_a}; end
            S_PAIR_B:  begin bus_wr = 1'b1; bus_bank = 1'b1; bus_reg = REG_PAIR;
                             bus_wdata = {set_b, clr_b}; end
            default: ;
        endcase
    end

    assign done = (state == S_DONE);

    // R6: at most one transfer strobe at a time
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr, bus_rd, bus_wr}) <= 1);

    // R6: a pending memory read holds its address
    p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

    // R3: OE write keeps non-matrix bits as read
    p_oe_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_reg == REG_OE) |->
        (((bus_wdata[BANK_W-1:0] ^ oe_q) & ~bank_pins(bus_bank)) == '0));

    // R7: gated request leaves the engine idle
    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !go_ok) |=> (state == S_IDLE));

    // R9: done follows an acknowledged write-back
    p_done_after_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_wr && mem_ack));

    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: pointer has advanced one step when done rises
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ptr_q == $past(ptr_q) + STEP));

endmodule

// File: rtl/gpio_matrix_engine.sv
// Top of the GPIO matrix engine. Wires the sequencer, one mask builder per
// bank (generated) and the input write-back stage.
// Assumes a single outstanding transfer on each port.
module gpio_matrix_engine
    import gpio_matrix_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SKIP_BITS = 2,
    parameter int PTR_STEP  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 start,
    input  logic [SKIP_BITS-1:0] xfer_phase,
    input  logic                 ptr_load,
    input  logic [ADDR_W-1:0]    ptr_init,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    input  logic                 mem_ack,
    output logic                 bus_rd,
    output logic                 bus_wr,
    output logic                 bus_bank,
    output logic [1:0]           bus_reg,
    output logic [63:0]          bus_wdata,
    input  logic [31:0]          bus_rdata,
    input  logic                 bus_ack,
    output logic                 done
);
    localparam int NUM_BANKS = 2;

    logic [WORD_W-1:0] word_q, word_upd;
    logic [BANK_W-1:0] oe_q, din_a_q, din_b_q;
    logic [BANK_W-1:0] oe_new [NUM_BANKS];
    logic [BANK_W-1:0] set_m  [NUM_BANKS];
    logic [BANK_W-1:0] clr_m  [NUM_BANKS];

    gpio_matrix_seq #(
        .ADDR_W(ADDR_W), .SKIP_BITS(SKIP_BITS), .PTR_STEP(PTR_STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .xfer_phase(xfer_phase), .ptr_load(ptr_load), .ptr_init(ptr_init),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_bank(bus_bank), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .word_q(word_q), .oe_q(oe_q), .din_a_q(din_a_q), .din_b_q(din_b_q),
        .oe_new_a(oe_new[0]), .oe_new_b(oe_new[1]),
        .set_a(set_m[0]), .clr_a(clr_m[0]), .set_b(set_m[1]), .clr_b(clr_m[1]),
        .word_upd(word_upd), .done(done)
    );

    // One mask builder per bank; both see the OE value latched for the
    // bank currently being serviced.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_matrix_bank #(.ON_B(b[0])) u_bank (
            .clk(clk), .rst_n(rst_n), .word(word_q), .oe_cur(oe_q),
            .oe_new(oe_new[b]), .set_mask(set_m[b]), .clr_mask(clr_m[b])
        );
    end

    gpio_matrix_sample u_sample (
        .word(word_q), .din_a(din_a_q), .din_b(din_b_q), .word_upd(word_upd)
    );

endmodule

// File: tb/tb_gpio_matrix_engine.sv
module tb_gpio_matrix_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, start = 1'b0, ptr_load = 1'b0;
    logic [1:0]  xfer_phase = '0;
    logic [15:0] ptr_init = '0;
    logic        mem_rd, mem_wr, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        bus_rd, bus_wr, bus_bank, bus_ack = 1'b0;
    logic [1:0]  bus_reg;
    logic [63:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        done;

    gpio_matrix_engine dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [16];
    logic [31:0] oe_reg [2];
    logic [31:0] din_reg [2];
    int          log_code [32];
    logic [63:0] log_data [32];
    logic [15:0] log_addr [32];
    int          n_log = 0;
    int          n_done = 0;
    int          map_b [16];
    int          map_bit [16];

    initial begin
        map_b   = '{1,1,1,1, 0,0,0,0,0,0,0, 1,1,1,1,1};
        map_bit = '{2,3,5,4, 13,12,28,18,15,14,19, 1,22,24,23,25};
    end

    // Bus models: acknowledge one cycle after a strobe and log the transfer.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        bus_ack <= 1'b0;
        if ((mem_rd || mem_wr) && !mem_ack) begin
            mem_ack <= 1'b1;
            log_code[n_log % 32] <= mem_rd ? 1 : 2;
            log_data[n_log % 32] <= {32'd0, mem_wdata};
            log_addr[n_log % 32] <= mem_addr;
            n_log <= n_log + 1;
            if (mem_rd) mem_rdata <= mem[mem_addr[5:2]];
            else        mem[mem_addr[5:2]] <= mem_wdata;
        end
        if ((bus_rd || bus_wr) && !bus_ack) begin
            bus_ack <= 1'b1;
            log_code[n_log % 32] <= 16 + 8*int'(bus_bank) + 2*int'(bus_reg) + int'(bus_wr);
            log_data[n_log % 32] <= bus_wdata;
            log_addr[n_log % 32] <= '0;
            n_log <= n_log + 1;
            if (bus_rd) bus_rdata <= (bus_reg == 2'd0) ? oe_reg[bus_bank] : din_reg[bus_bank];
            if (bus_wr && bus_reg == 2'd0) oe_reg[bus_bank] <= bus_wdata[31:0];
        end
        if (done) n_done <= n_done + 1;
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_oe(int bank, logic [31:0] w, logic [31:0] oe);
        for (int c = 0; c < 16; c++)
            if (map_b[c] == bank) oe[map_bit[c]] = w[c];
        return oe;
    endfunction

    function automatic logic [63:0] exp_pair(int bank, logic [31:0] w);
        logic [31:0] s = '0, k = '0;
        for (int c = 0; c < 16; c++)
            if (map_b[c] == bank && !w[c]) begin
                if (w[c+16]) s[map_bit[c]] = 1'b1;
                else         k[map_bit[c]] = 1'b1;
            end
        return {s, k};
    endfunction

    function automatic logic [31:0] exp_word(logic [31:0] w);
        logic [31:0] r = w;
        for (int c = 0; c < 16; c++)
            if (w[c]) r[c+16] = din_reg[map_b[c]][map_bit[c]];
        return r;
    endfunction

    task automatic pulse_start(input logic [1:0] ph);
        @(negedge clk); xfer_phase = ph; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    // One processed frame with full checking of order, values and pointer.
    task automatic run_frame(input string name, input logic [31:0] w,
                             input logic [31:0] oea, input logic [31:0] oeb,
                             input logic [31:0] dia, input logic [31:0] dib,
                             input logic [15:0] addr);
        bit seen;
        int exp_code [10] = '{1, 16, 17, 24, 25, 18, 26, 21, 29, 2};
        mem[addr[5:2]] = w;
        oe_reg[0] = oea; oe_reg[1] = oeb;
        din_reg[0] = dia; din_reg[1] = dib;
        n_log = 0;
        pulse_start(2'b00);
        wait_done(seen);
        check({name, " R9 done seen"}, 64'(seen), 64'd1);
        @(negedge clk);
        check({name, " R9 done one cycle"}, 64'(done), 64'd0);
        check({name, " R6 transfer count"}, 64'(n_log), 64'd10);
        for (int i = 0; i < 10; i++)
            check({name, " R6 order"}, 64'(log_code[i]), 64'(exp_code[i]));
        check({name, " R8 fetch address"}, 64'(log_addr[0]), 64'(addr));
        check({name, " R8 store address"}, 64'(log_addr[9]), 64'(addr));
        check({name, " R1 R2 R3 R4 OE A"}, log_data[2], {32'd0, exp_oe(0, w, oea)});
        check({name, " R1 R2 R3 R4 OE B"}, log_data[4], {32'd0, exp_oe(1, w, oeb)});
        check({name, " R1 R2 R3 R4 pair A"}, log_data[7], exp_pair(0, w));
        check({name, " R1 R2 R3 R4 pair B"}, log_data[8], exp_pair(1, w));
        check({name, " R5 stored word"}, {32'd0, mem[addr[5:2]]}, {32'd0, exp_word(w)});
    endtask

    task automatic t_reset();
        // R11: idle with no strobes after reset
        check("R11 reset strobes", {60'd0, mem_rd, mem_wr, bus_rd, bus_wr}, 64'd0);
        check("R11 reset done", 64'(done), 64'd0);
    endtask

    task automatic t_gating();
        int before_done = n_done;
        n_log = 0;
        enable = 1'b0;
        pulse_start(2'b00);
        repeat (20) @(negedge clk);
        check("R7 disabled no transfer", 64'(n_log), 64'd0);
        enable = 1'b1;
        pulse_start(2'b01);
        repeat (20) @(negedge clk);
        pulse_start(2'b10);
        repeat (20) @(negedge clk);
        check("R7 phase nonzero no transfer", 64'(n_log), 64'd0);
        check("R7 no done", 64'(n_done), 64'(before_done));
    endtask

    task automatic t_busy();
        bit seen;
        int before_done;
        mem[4] = 32'h0000_0000;
        before_done = n_done;
        n_log = 0;
        pulse_start(2'b00);
        repeat (4) @(negedge clk);
        pulse_start(2'b00);
        wait_done(seen);
        repeat (30) @(negedge clk);
        check("R10 single frame transfers", 64'(n_log), 64'd10);
        check("R10 single done", 64'(n_done - before_done), 64'd1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        enable = 1'b1;
        ptr_load = 1'b1; ptr_init = 16'h0040;
        @(negedge clk); ptr_load = 1'b0;
        // all outputs, mixed levels
        run_frame("all-out", 32'hA5C3_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                  32'h0, 32'h0, 16'h0040);
        // all inputs, distinct input patterns per bank
        run_frame("all-in", 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000,
                  32'h1005_A000, 32'h0280_003C, 16'h0044);
        // mixed directions, non-matrix OE bits preset
        run_frame("mixed", 32'h6B2D_0F0F, 32'h1234_5678, 32'h8765_4321,
                  32'hFFFF_FFFF, 32'h5555_AAAA, 16'h0048);
        // R7: gated requests, then the pointer must still be at 0x004C
        t_gating();
        run_frame("after-gate", 32'hFFFF_00F0, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
                  32'h0008_4000, 32'h0140_0024, 16'h004C);
        // R10: start while busy; word at 0x0050
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule